// File: doc/BRIEF.md
# Configurable SPI Master/Slave Shift Engine

This block moves one serial word at a time over a three-wire SPI link and can take either side of the link. A mode input selects the side. As master it makes the serial clock from the system clock through a programmable divider and starts a frame when it sees a start strobe. As slave it follows a serial clock that some other device drives. The frame is 8 to 16 bits long. Clock polarity and clock phase are chosen at run time.

The host puts a word on the parallel transmit input and pulses the start strobe. When the last bit has been captured, the received word appears on the parallel receive output together with a one-cycle done pulse. A 4-bit length code sets the frame length. In master mode that code applies only when a length-enable flag is set. In slave mode the code always applies.

Top module: `spi_shifter`

## Requirements
- R1: With `cfg_master`=1 the block drives `sck_out` and frames its own transfers. With `cfg_master`=0 it never toggles `sck_out`; it shifts on edges of `sck_in`, samples `mosi_in` and drives `miso_out`.
- R2: Length code 4'b1000 through 4'b1111 selects a frame of 8 through 15 bits (the code's numeric value). Code 4'b0000 selects 16 bits.
- R3: Length codes 4'b0001 through 4'b0111 are treated as 8-bit frames.
- R4: In master mode with `cfg_len_en`=0, every frame is exactly 8 bits, whatever the length code.
- R5: In slave mode the length code sets the frame length even when `cfg_len_en`=0.
- R6: `sck_out` rests at `cfg_cpol` when no transfer is running (0 = low, 1 = high), and it returns to that level after every master frame.
- R7: With `cfg_cpha`=0, data is captured on the leading SCK edge (the edge leaving the rest level) and changed on the trailing edge, and in master mode the first bit is on `mosi_out` before the first edge. With `cfg_cpha`=1, data is changed on the leading edge and captured on the trailing edge.
- R8: In master mode each SCK half period lasts exactly `cfg_div` system clocks, so the SCK frequency is fsys/(2·`cfg_div`), for `cfg_div` from 2 to 255.
- R9: With `cfg_div` equal to 0 or 1, a master start strobe is refused: `busy` stays low, `sck_out` stays at rest and no done pulse appears.
- R10: Bits are sent and received most significant first. A received frame shorter than 16 bits sits in the low bits of `rx_word`, and the upper bits are zero.
- R11: `rx_done` is high for exactly one system clock per frame, and `rx_word` holds the new frame from that cycle on.
- R12: A start strobe that arrives while `busy` is high has no effect on the running frame: its word, its length and its result are all unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_cpol | input | 1 | SCK rest level |
| cfg_cpha | input | 1 | 0 = capture on the leading edge, 1 = capture on the trailing edge |
| cfg_len_code | input | 4 | Frame length code |
| cfg_len_en | input | 1 | Master only: apply the length code (else 8 bits) |
| cfg_div | input | 8 | SCK half period in system clocks (2 to 255 legal) |
| tx_word | input | 16 | Word to send, right-justified |
| tx_start | input | 1 | Start strobe (master) or load strobe (slave) |
| rx_word | output | 16 | Last received word, right-justified |
| rx_done | output | 1 | One-cycle pulse when a frame's last bit is captured |
| busy | output | 1 | A frame is in progress |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_in | input | 1 | Serial clock received in slave mode |
| mosi_out | output | 1 | Master serial data out |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| miso_in | input | 1 | Master serial data in |

## Verification
In master mode a frame of L bits ends 2·L·`cfg_div` system clocks after the clock that registers the start strobe. `rx_done` fires on the final capturing tick, which is either that same tick or one half period earlier. The bench therefore waits until `busy` falls, allows three more cycles, and only then compares the done-pulse count, the received word and the rest level. In slave mode every `sck_in` and `mosi_in` change takes three system clocks to pass the input synchronizer before the engine acts on it. The bench holds each half period for six clocks and reads `miso_out` at the end of the half period, after any shift has settled. All sampling happens at the falling clock edge, and inputs change 1 ns after that edge.

// File: rtl/spi_pkg.sv
// Package spi_pkg
// Shared constants, the frame-length type and the length-code decoder used
// by the SPI shift engine. Assumes frames never exceed 16 bits.
package spi_pkg;
    localparam int unsigned FRAME_MAX = 16;
    localparam int unsigned LEN_W     = 5;

    typedef logic [LEN_W-1:0] len_t;

    // Decode a 4-bit length code: 0 -> 16, 8..15 -> itself, 1..7 -> 8.
    function automatic len_t decode_len(input logic [3:0] code);
        if (code == 4'b0000)
            return len_t'(FRAME_MAX);
        else if (code[3])
            return len_t'({2'b01, code[2:0]});
        else
            return len_t'(8);
    endfunction
endpackage

// File: rtl/spi_len_sel.sv
// Module spi_len_sel
// Chooses the active frame length from the role, the length code and the
// enable flag. A master with the enable flag clear always uses 8 bits; a
// slave always honours the code. Purely combinational.
module spi_len_sel
    import spi_pkg::*;
(
    input  logic       is_master,
    input  logic [3:0] len_code,
    input  logic       len_en,
    output len_t       len_o
);
    // Pick the forced 8-bit length or the decoded code.
    always_comb begin
        if (is_master && !len_en)
            len_o = len_t'(8);
        else
            len_o = decode_len(len_code);
    end

    // R2: the chosen length always stays inside the supported range.
    always_comb begin
        a_r2_len_range: assert (len_o >= len_t'(8) && len_o <= len_t'(FRAME_MAX))
            else $error("frame length out of range");
    end
endmodule

// File: rtl/spi_clkgen.sv
// Module spi_clkgen
// Modulus counter that raises a one-cycle tick every DIV system clocks while
// run is high. Each tick marks one SCK half period. Assumes div >= 2 during run.
module spi_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count system clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == div - 1'b1)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div - 1'b1);

    // R8: the counter never passes the programmed modulus.
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < div));
endmodule

// File: rtl/spi_sck_sync.sv
// Module spi_sck_sync
// Brings the slave-side SCK and MOSI into the system clock domain through two
// flops each and finds SCK transitions. Assumes SCK is slow against clk, at
// least a few system clocks per half period.
module spi_sck_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic data_in,
    input  logic cpol,
    output logic edge_o,
    output logic lead_o,
    output logic data_o
);
    logic s1, s2, s3;
    logic d1, d2;

    // Shift the raw pins through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
            d1 <= 1'b0; d2 <= 1'b0;
        end else begin
            s1 <= sck_in; s2 <= s1; s3 <= s2;
            d1 <= data_in; d2 <= d1;
        end
    end

    assign edge_o = s2 ^ s3;
    assign lead_o = (s3 == cpol);
    assign data_o = d2;
endmodule

// File: rtl/spi_shift_core.sv
// Module spi_shift_core
// Frame engine shared by both roles. Master edges come from the divider tick,
// slave edges from the synchronizer. Keeps the transmit and receive shift
// registers, the bit counter and the master SCK state. Assumes the
// configuration stays stable while a frame is running.
module spi_shift_core
    import spi_pkg::*;
#(
    parameter int unsigned DW = FRAME_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master,
    input  logic          cpol,
    input  logic          cpha,
    input  len_t          len_live,
    input  logic          div_ok,
    input  logic [DW-1:0] tx_word,
    input  logic          tx_start,
    input  logic          tick,
    input  logic          s_edge,
    input  logic          s_lead,
    input  logic          s_data,
    input  logic          miso_in,
    output logic          run,
    output logic          sck_q,
    output logic          out_bit,
    output logic [DW-1:0] rx_word,
    output logic          rx_done,
    output logic          busy_o
);
    localparam int unsigned EW = LEN_W + 1;
    localparam int unsigned IW = $clog2(DW);

    logic          mst_active, in_frame;
    logic [DW-1:0] tx_sh, rx_sh, rx_base;
    len_t          len_q, cap_cnt;
    logic [EW-1:0] ecnt;
    logic [IW-1:0] top_idx;
    logic edge_ev, lead_ev, in_bit, cap_ev, chg_ev;
    logic frame_start, last_cap, load, start_ok, end_ev;

    assign busy_o  = mst_active || in_frame;
    assign run     = mst_active;
    assign top_idx = IW'(len_q - 1'b1);
    assign out_bit = tx_sh[top_idx];

    // Classify the current SCK event and decide what the frame does with it.
    always_comb begin
        edge_ev     = master ? tick : s_edge;
        lead_ev     = master ? (tick && (sck_q == cpol)) : (s_edge && s_lead);
        in_bit      = master ? miso_in : s_data;
        frame_start = edge_ev && !in_frame && lead_ev;
        cap_ev      = edge_ev && (in_frame || lead_ev) && (lead_ev != cpha);
        chg_ev      = edge_ev && in_frame && (lead_ev == cpha);
        last_cap    = cap_ev && (cap_cnt == len_q - 1'b1);
        load        = tx_start && !busy_o && (!master || div_ok);
        start_ok    = load && master;
        end_ev      = tick && mst_active &&
                      (ecnt == ({1'b0, len_q} << 1) - 1'b1);
        rx_base     = frame_start ? '0 : rx_sh;
    end

    // Master run state, SCK level and edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_active <= 1'b0;
            ecnt       <= '0;
            sck_q      <= 1'b0;
        end else if (start_ok) begin
            mst_active <= 1'b1;
            ecnt       <= '0;
            sck_q      <= cpol;
        end else if (tick) begin
            sck_q <= ~sck_q;
            ecnt  <= ecnt + 1'b1;
            if (end_ev)
                mst_active <= 1'b0;
        end
    end

    // Follow the live frame length whenever no frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= len_t'(8);
        else if (!busy_o)
            len_q <= len_live;
    end

    // Load the transmit word and shift it on each change edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= tx_word;
        else if (chg_ev)
            tx_sh <= tx_sh << 1;
    end

    // Capture bits, count them, and publish the word on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh    <= '0;
            cap_cnt  <= '0;
            in_frame <= 1'b0;
            rx_word  <= '0;
            rx_done  <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (frame_start)
                in_frame <= 1'b1;
            if (cap_ev) begin
                rx_sh <= {rx_base[DW-2:0], in_bit};
                if (last_cap) begin
                    cap_cnt  <= '0;
                    in_frame <= 1'b0;
                    rx_word  <= {rx_base[DW-2:0], in_bit};
                    rx_done  <= 1'b1;
                end else begin
                    cap_cnt <= cap_cnt + 1'b1;
                end
            end else if (frame_start) begin
                rx_sh <= '0;
            end
        end
    end

    // R11: the done pulse never lasts more than one cycle.
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R6: a master frame always leaves SCK back at its rest level.
    a_r6_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mst_active) |-> (sck_q == cpol));

    // R9: a master with an illegal divider never becomes busy.
    a_r9_bad_div_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (master && !div_ok && !busy_o) |=> !busy_o);

    // R10: the bit counter stays below the frame length during a frame.
    a_r10_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> (cap_cnt < len_q));

    // R12: a strobe during a running master frame does not restart it.
    a_r12_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_active && tx_start && !end_ev && !tick) |=> (ecnt == $past(ecnt)));
endmodule

// File: rtl/spi_shifter.sv
// Module spi_shifter (top)
// Single-channel SPI engine for either role. Connects the length selector,
// the SCK divider, the slave input synchronizer and the frame engine, and
// steers the pins by role. Assumes the configuration is changed only between
// frames.
module spi_shifter
    import spi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_master,
    input  logic                 cfg_cpol,
    input  logic                 cfg_cpha,
    input  logic [3:0]           cfg_len_code,
    input  logic                 cfg_len_en,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic [FRAME_MAX-1:0] tx_word,
    input  logic                 tx_start,
    output logic [FRAME_MAX-1:0] rx_word,
    output logic                 rx_done,
    output logic                 busy,
    output logic                 sck_out,
    input  logic                 sck_in,
    output logic                 mosi_out,
    input  logic                 mosi_in,
    output logic                 miso_out,
    input  logic                 miso_in
);
    len_t len_live;
    logic div_ok, tick, run, sck_q, out_bit;
    logic s_edge, s_lead, s_data;

    assign div_ok = (cfg_div >= DIV_W'(2));

    spi_len_sel u_len (
        .is_master (cfg_master),
        .len_code  (cfg_len_code),
        .len_en    (cfg_len_en),
        .len_o     (len_live)
    );

    spi_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_sck_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_in  (sck_in),
        .data_in (mosi_in),
        .cpol    (cfg_cpol),
        .edge_o  (s_edge),
        .lead_o  (s_lead),
        .data_o  (s_data)
    );

    spi_shift_core #(.DW(FRAME_MAX)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .master   (cfg_master),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .len_live (len_live),
        .div_ok   (div_ok),
        .tx_word  (tx_word),
        .tx_start (tx_start),
        .tick     (tick),
        .s_edge   (s_edge),
        .s_lead   (s_lead),
        .s_data   (s_data),
        .miso_in  (miso_in),
        .run      (run),
        .sck_q    (sck_q),
        .out_bit  (out_bit),
        .rx_word  (rx_word),
        .rx_done  (rx_done),
        .busy_o   (busy)
    );

    assign sck_out  = run ? sck_q : cfg_cpol;
    assign mosi_out = cfg_master & out_bit;
    assign miso_out = ~cfg_master & out_bit;
endmodule

// File: tb/tb_spi_shifter.sv
`timescale 1ns/1ps
// Bench for spi_shifter. The master side runs in loopback (miso_in tied to
// mosi_out). The slave side is driven by a modelled master inside the bench.
module tb_spi_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [3:0]  cfg_len_code = 4'b1000;
    logic        cfg_len_en = 1'b1;
    logic [7:0]  cfg_div = 8'd2;
    logic [15:0] tx_word = '0;
    logic        tx_start = 1'b0;
    logic [15:0] rx_word;
    logic        rx_done, busy, sck_out, mosi_out, miso_out;
    logic        sck_in = 1'b0, mosi_in = 1'b0;
    logic        miso_in;

    int checks = 0, fails = 0, wd_cyc = 0;
    localparam int WD_LIMIT = 150000;
    localparam int H = 6;

    // Monitor state
    int trans, lead_cnt, nbits, done_cnt, ncyc, last_t, hp_min, hp_max;
    logic [15:0] cap_bits;
    logic prev_sck, prev_mosi, busy_seen;

    always #4 clk = ~clk;

    assign miso_in = mosi_out;

    spi_shifter dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_len_code(cfg_len_code), .cfg_len_en(cfg_len_en),
        .cfg_div(cfg_div), .tx_word(tx_word), .tx_start(tx_start),
        .rx_word(rx_word), .rx_done(rx_done), .busy(busy), .sck_out(sck_out),
        .sck_in(sck_in), .mosi_out(mosi_out), .mosi_in(mosi_in),
        .miso_out(miso_out), .miso_in(miso_in)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        wd_cyc++;
        if (wd_cyc == WD_LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", wd_cyc);
            summary();
            $finish;
        end
    end

    // Sample SCK / MOSI away from the active edge and log edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_out !== prev_sck) begin
                trans++;
                if (trans > 1) begin
                    if (ncyc - last_t < hp_min) hp_min = ncyc - last_t;
                    if (ncyc - last_t > hp_max) hp_max = ncyc - last_t;
                end
                last_t = ncyc;
                if (prev_sck == cfg_cpol) lead_cnt++;
                if ((prev_sck == cfg_cpol) != cfg_cpha) begin
                    cap_bits = {cap_bits[14:0], prev_mosi};
                    nbits++;
                end
            end
            prev_sck  = sck_out;
            prev_mosi = mosi_out;
            if (rx_done) done_cnt++;
            if (busy) busy_seen = 1'b1;
            ncyc++;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic mon_clear();
        trans = 0; lead_cnt = 0; nbits = 0; done_cnt = 0; ncyc = 0; last_t = 0;
        hp_min = 1000000; hp_max = 0; cap_bits = '0; busy_seen = 1'b0;
        prev_sck = sck_out; prev_mosi = mosi_out;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] code, input logic en, input logic mst);
        if (mst && !en) return 8;
        if (code == 4'b0000) return 16;
        if (code[3]) return int'(code);
        return 8;
    endfunction

    function automatic logic [15:0] mask_of(input int n);
        return (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    endfunction

    function automatic string req_of(input logic [3:0] code, input logic en);
        if (!en) return "R4";
        if (code == 4'b0000 || code[3]) return "R2";
        return "R3";
    endfunction

    // One master frame in loopback; optional second strobe while busy.
    task automatic mxfer(input logic pol, input logic pha, input logic [3:0] code,
                         input logic en, input logic [7:0] dv, input logic [15:0] w,
                         input logic inject);
        int n, guard;
        logic [15:0] m;
        string rq;
        n = exp_len(code, en, 1'b1);
        m = mask_of(n);
        rq = req_of(code, en);
        step();
        cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha; cfg_len_code = code;
        cfg_len_en = en; cfg_div = dv; tx_word = w;
        step();
        mon_clear();
        tx_start = 1'b1;
        step();
        tx_start = 1'b0;
        guard = 0;
        while (busy && guard < 20000) begin
            step();
            guard++;
            if (inject && guard == 5) begin
                tx_word = ~w; tx_start = 1'b1;
            end else begin
                tx_start = 1'b0;
            end
        end
        tx_start = 1'b0;
        repeat (3) step();
        chk({rq, " leading SCK edges per frame"}, lead_cnt, n);
        chk("R10 received word right-justified", int'(rx_word), int'(w & m));
        chk("R7 MOSI bits at capture edges, MSB first", int'(cap_bits & m), int'(w & m));
        chk("R7 capture edge count", nbits, n);
        chk("R11 done pulse cycles", done_cnt, 1);
        chk("R6 SCK rest level after frame", int'(sck_out), int'(pol));
        chk("R8 shortest half period", hp_min, int'(dv));
        chk("R8 longest half period", hp_max, int'(dv));
        chk("R1 master toggles SCK", int'(trans == 2 * n), 1);
        if (inject) begin
            chk("R12 result after strobe while busy", int'(rx_word), int'(w & m));
            chk("R12 frame length after strobe while busy", lead_cnt, n);
        end
    endtask

    // One slave frame driven by the bench acting as master.
    task automatic sxfer(input logic pol, input logic pha, input logic [3:0] code,
                         input logic en, input logic [15:0] win, input logic [15:0] wout);
        int n;
        logic [15:0] m, got;
        string rq;
        n = exp_len(code, en, 1'b0);
        m = mask_of(n);
        rq = (code == 4'b0000 || code[3]) ? "R5" : "R3";
        step();
        cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha; cfg_len_code = code;
        cfg_len_en = en; sck_in = pol; mosi_in = 1'b0; tx_word = wout;
        repeat (6) step();
        mon_clear();
        tx_start = 1'b1;
        step();
        tx_start = 1'b0;
        step();
        got = '0;
        for (int i = n - 1; i >= 0; i--) begin
            if (!pha) begin
                mosi_in = win[i];
                repeat (H) step();
                got = {got[14:0], miso_out};
                sck_in = ~pol;
                repeat (H) step();
                sck_in = pol;
            end else begin
                sck_in = ~pol;
                mosi_in = win[i];
                repeat (H) step();
                got = {got[14:0], miso_out};
                sck_in = pol;
                repeat (H) step();
            end
        end
        repeat (10) step();
        chk({rq, " slave received word, enable ignored"}, int'(rx_word), int'(win & m));
        chk("R7 slave MISO bits MSB first", int'(got & m), int'(wout & m));
        chk("R11 slave done pulse cycles", done_cnt, 1);
        chk("R1 slave leaves sck_out alone", trans, 0);
    endtask

    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        step();
        prev_sck = sck_out; prev_mosi = mosi_out;
        chk("R6 reset SCK rest level", int'(sck_out), 0);
        chk("R11 reset done low", int'(rx_done), 0);
        chk("R9 reset busy low", int'(busy), 0);
        chk("R10 reset receive word", int'(rx_word), 0);

        // Length codes x all four polarity/phase modes.
        for (int md = 0; md < 4; md++) begin
            for (int c = 0; c < 16; c++) begin
                mxfer(md[1], md[0], c[3:0], 1'b1, 8'd2,
                      16'(16'hB4E1 ^ (c * 4793) ^ (md << 7)), 1'b0);
            end
        end

        // Length enable clear forces 8 bits in master mode.
        mxfer(1'b0, 1'b0, 4'b0000, 1'b0, 8'd3, 16'hF0F5, 1'b0);
        mxfer(1'b1, 1'b1, 4'b1001, 1'b0, 8'd3, 16'h3C96, 1'b0);
        mxfer(1'b0, 1'b1, 4'b1111, 1'b0, 8'd3, 16'hFFFF, 1'b0);
        mxfer(1'b1, 1'b0, 4'b0011, 1'b0, 8'd3, 16'h8001, 1'b0);

        // Divider sweep.
        for (int d = 2; d < 10; d++)
            mxfer(1'b1, 1'b0, 4'b1000, 1'b1, 8'(d), 16'(16'h5A00 + d), 1'b0);
        mxfer(1'b0, 1'b1, 4'b1000, 1'b1, 8'd255, 16'h00C3, 1'b0);

        // Illegal divider values.
        for (int d = 0; d < 2; d++) begin
            step();
            cfg_master = 1'b1; cfg_cpol = d[0]; cfg_cpha = 1'b0;
            cfg_len_code = 4'b1000; cfg_len_en = 1'b1; cfg_div = 8'(d);
            tx_word = 16'h00AA;
            step();
            mon_clear();
            tx_start = 1'b1;
            step();
            tx_start = 1'b0;
            repeat (40) step();
            chk("R9 busy never set with illegal divider", int'(busy_seen), 0);
            chk("R9 SCK stays at rest with illegal divider", trans, 0);
            chk("R9 no done with illegal divider", done_cnt, 0);
        end

        // Strobe while busy.
        mxfer(1'b0, 1'b0, 4'b1100, 1'b1, 8'd2, 16'h0ACE, 1'b1);
        mxfer(1'b1, 1'b1, 4'b0000, 1'b1, 8'd3, 16'h9D27, 1'b1);

        // Slave frames, length enable clear.
        for (int md = 0; md < 4; md++) begin
            sxfer(md[1], md[0], 4'b0000, 1'b0, 16'(16'hC35A ^ md), 16'(16'h1E87 + md));
            sxfer(md[1], md[0], 4'b1100, 1'b0, 16'(16'h0B6D ^ md), 16'(16'h0F31 + md));
            sxfer(md[1], md[0], 4'b1000, 1'b1, 16'(16'h00A7 ^ md), 16'(16'h0059 + md));
            sxfer(md[1], md[0], 4'b0101, 1'b0, 16'(16'h7766 ^ md), 16'(16'h12F0 + md));
        end

        summary();
        $finish;
    end
endmodule